// File: doc/BRIEF.md
# Serial Scan Ring Engine

This block lets a host program an on-chip serial configuration ring through two 64-bit registers. The control register holds a clock-divide exponent, an observe selector that picks which group's serial output feeds back into the shift word, and a bypass mask with one bit per group. The data register holds a 32-bit shift word, a bit count, a one-hot group select and three command bits: shift, capture and update.

Writing a command starts an operation. The engine makes a divided scan clock and, for a shift, moves between 1 and 32 bits. The word's LSB feeds the selected rings, and the observed ring's output fills the word from the MSB. Capture loads each selected ring from its lane image. Update copies each selected ring into its lane image. Each group's ring is four 268-bit lane segments joined into one 1072-bit loop. The command bit stays set until its operation is finished, so software polls the data register to learn when the operation is done.

Top module: `scan_ring_engine`

## Requirements
- R1: After reset both registers read zero and the scan clock output is low.
- R2: Control register fields are the divide exponent in bits 3:0, the observe select from bit 8 and the bypass mask from bit 16. Written field values read back unchanged. All other bits read zero.
- R3: Data register fields are the shift word in bits 31:0, the bit count minus one in bits 36:32 and the group select from bit 40. The command bits are shift at bit 56, capture at bit 57 and update at bit 58.
- R4: While an operation runs, the scan clock has a period of 2^(e+2) system clocks, where e is the divide exponent. Its first rising edge comes 2^(e+1) cycles after the write, and there is one rising edge per bit moved. It is low when the engine is idle.
- R5: Each scan edge sends word bit 0 into the top end of the selected rings, moves the word right by one, and places the observed ring's lowest bit into word bit 31. After N bits, the returned bits are in the upper N bits of the word, with the first one returned at bit 32-N.
- R6: A command bit reads set from the cycle after the write until it clears. A shift stays set for 2^(e+1)+(N-1)*2^(e+2)+1 cycles. A capture or an update stays set for 2^(e+1)+1 cycles.
- R7: A data register write made while any command bit is set is ignored.
- R8: When a write sets several command bits, only one is kept: shift wins over capture, and capture wins over update.
- R9: A bit shifted into a ring comes back out after 1072 more bits have been shifted through that ring.
- R10: When the observed group is bypassed, its ring is left out of the path, so a shift of N bits rotates the word right by N. Bypassed groups do not shift.
- R11: Capture loads each selected ring from its lane image. After reset, bit i of a lane image is 1 exactly when i mod 3 is 0, where bit 0 is the first bit to leave the ring.
- R12: Update copies each selected ring into its lane image. A later capture makes this visible.
- R13: Only groups whose select bit is set shift or capture. The returned bits come from the group named by the observe select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the register chosen by reg_addr |
| scan_clk | output | 1 | Divided scan clock |

## Verification
The bench measures how long each command bit stays set, down to the exact cycle, and counts scan clock edges. An off-by-one in the divider or in the completion cycle therefore shows up as a wrong count. It sends data through a full 1072-bit ring to catch a chain of the wrong length. It also writes new commands while one is still running: a design that accepts such a write would corrupt the returned word. Capture and update are checked against each other using the mod-3 lane pattern. A design that ignored update, or captured into the wrong group, would return a different pattern. Writes that set several command bits at once show whether the lower-priority commands are correctly dropped.

// File: rtl/scan_ring_pkg.sv
// Package: register layout and command encoding shared by the scan ring engine.
// Assumes 64-bit registers and a 32-bit shift word; field positions are fixed
// because host software decodes them.
package scan_ring_pkg;
    localparam int REG_W         = 64;
    localparam int WORD_W        = 32;
    localparam int CNT_W         = 5;
    localparam int CTL_DIV_LSB   = 0;
    localparam int CTL_OBS_LSB   = 8;
    localparam int CTL_BYP_LSB   = 16;
    localparam int DAT_CNT_LSB   = 32;
    localparam int DAT_SEL_LSB   = 40;
    localparam int DAT_SHIFT_BIT = 56;
    localparam int DAT_CAP_BIT   = 57;
    localparam int DAT_UPD_BIT   = 58;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2,
        OP_UPDATE  = 2'd3
    } scan_op_e;

    // Keeps one command out of several requested ones: shift, then capture, then update.
    function automatic scan_op_e pick_op(input logic sh, input logic cap, input logic upd);
        if (sh)  return OP_SHIFT;
        if (cap) return OP_CAPTURE;
        if (upd) return OP_UPDATE;
        return OP_IDLE;
    endfunction
endpackage

// File: rtl/scan_clkdiv.sv
// Module: scan clock divider. Counts system clocks while an operation runs and
// gives a tick on the cycle just before each scan clock rising edge.
// Assumes run drops for at least one cycle between operations, which restarts the count.
module scan_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_exp,
    output logic             tick,
    output logic             scan_clk
);
    localparam int CW = (1 << DIV_W) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_m1;
    logic [CW-1:0] mask;

    // Phase limits for the current exponent.
    always_comb begin
        half_m1 = (CW'(1) << (32'(div_exp) + 1)) - CW'(1);
        mask    = (CW'(1) << (32'(div_exp) + 2)) - CW'(1);
    end

    // Counter runs only during an operation and starts again from zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + CW'(1);
    end

    // Tick sits on the last low-phase cycle; the clock is high in the second half.
    always_comb begin
        tick     = run && ((cnt_q & mask) == half_m1);
        scan_clk = run && ((cnt_q & mask) > half_m1);
    end

    a_r4_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> scan_clk) else $error("scan clock did not rise after tick");
    a_r4_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_clk) |-> $past(tick)) else $error("scan clock rose without tick");
endmodule

// File: rtl/scan_ctrl_regs.sv
// Module: host registers and command sequencer. Holds control and data fields,
// accepts a command only when idle, steps the shift word on each tick, and
// clears the command one cycle after the final scan edge.
// Assumes tick comes from scan_clkdiv running with busy.
module scan_ctrl_regs
    import scan_ring_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int DIV_W      = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_addr,
    input  logic [REG_W-1:0]            reg_wdata,
    output logic [REG_W-1:0]            reg_rdata,
    input  logic                        tick,
    input  logic                        chain_out,
    output logic                        busy,
    output logic                        step_shift,
    output logic                        step_cap,
    output logic                        step_upd,
    output logic                        word_lsb,
    output logic [DIV_W-1:0]            run_div,
    output logic [$clog2(NUM_GROUPS)-1:0] obs_sel,
    output logic [NUM_GROUPS-1:0]       bypass,
    output logic [NUM_GROUPS-1:0]       group_sel
);
    localparam int OBS_W = $clog2(NUM_GROUPS);
    localparam int REM_W = CNT_W + 1;

    logic [DIV_W-1:0]      div_q;
    logic [OBS_W-1:0]      obs_q;
    logic [NUM_GROUPS-1:0] byp_q;
    logic [WORD_W-1:0]     word_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [NUM_GROUPS-1:0] sel_q;
    scan_op_e              op_q;
    scan_op_e              new_op;
    logic [REM_W-1:0]      remain_q;
    logic                  fin_q;
    logic [DIV_W-1:0]      run_div_q;
    logic                  data_wr;
    logic                  unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // Decode of the incoming command and the accepted data write.
    always_comb begin
        new_op  = pick_op(reg_wdata[DAT_SHIFT_BIT], reg_wdata[DAT_CAP_BIT], reg_wdata[DAT_UPD_BIT]);
        busy    = (op_q != OP_IDLE);
        data_wr = reg_wr && reg_addr && !busy;
    end

    // Control register storage; writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            obs_q <= '0;
            byp_q <= '0;
        end else if (reg_wr && !reg_addr) begin
            div_q <= reg_wdata[CTL_DIV_LSB +: DIV_W];
            obs_q <= reg_wdata[CTL_OBS_LSB +: OBS_W];
            byp_q <= reg_wdata[CTL_BYP_LSB +: NUM_GROUPS];
        end
    end

    // Data register and sequencer: load on an idle write, step on ticks, retire after fin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            cnt_q     <= '0;
            sel_q     <= '0;
            op_q      <= OP_IDLE;
            remain_q  <= '0;
            fin_q     <= 1'b0;
            run_div_q <= '0;
        end else if (data_wr) begin
            word_q    <= reg_wdata[WORD_W-1:0];
            cnt_q     <= reg_wdata[DAT_CNT_LSB +: CNT_W];
            sel_q     <= reg_wdata[DAT_SEL_LSB +: NUM_GROUPS];
            op_q      <= new_op;
            remain_q  <= (new_op == OP_SHIFT) ? ({1'b0, reg_wdata[DAT_CNT_LSB +: CNT_W]} + REM_W'(1))
                                              : REM_W'(1);
            fin_q     <= 1'b0;
            run_div_q <= div_q;
        end else if (fin_q) begin
            op_q  <= OP_IDLE;
            fin_q <= 1'b0;
        end else if (busy && tick) begin
            if (op_q == OP_SHIFT) word_q <= {chain_out, word_q[WORD_W-1:1]};
            remain_q <= remain_q - REM_W'(1);
            if (remain_q == REM_W'(1)) fin_q <= 1'b1;
        end
    end

    // Per-edge strobes toward the rings.
    always_comb begin
        step_shift = busy && tick && !fin_q && (op_q == OP_SHIFT);
        step_cap   = busy && tick && !fin_q && (op_q == OP_CAPTURE);
        step_upd   = busy && tick && !fin_q && (op_q == OP_UPDATE);
        word_lsb   = word_q[0];
        run_div    = run_div_q;
        obs_sel    = obs_q;
        bypass     = byp_q;
        group_sel  = sel_q;
    end

    // Read mux: only defined fields are returned, all else zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[WORD_W-1:0]                = word_q;
            reg_rdata[DAT_CNT_LSB +: CNT_W]      = cnt_q;
            reg_rdata[DAT_SEL_LSB +: NUM_GROUPS] = sel_q;
            reg_rdata[DAT_SHIFT_BIT]             = (op_q == OP_SHIFT);
            reg_rdata[DAT_CAP_BIT]               = (op_q == OP_CAPTURE);
            reg_rdata[DAT_UPD_BIT]               = (op_q == OP_UPDATE);
        end else begin
            reg_rdata[CTL_DIV_LSB +: DIV_W]      = div_q;
            reg_rdata[CTL_OBS_LSB +: OBS_W]      = obs_q;
            reg_rdata[CTL_BYP_LSB +: NUM_GROUPS] = byp_q;
        end
    end

    a_r6_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !busy) else $error("command bit did not clear after final edge");
    a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wr && reg_addr |=> $stable(cnt_q) && $stable(sel_q))
        else $error("data write accepted while busy");
    a_r8_shift_wins: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && reg_wdata[DAT_SHIFT_BIT] |=> op_q == OP_SHIFT)
        else $error("shift did not take priority");
    a_r5_msb_fill: assert property (@(posedge clk) disable iff (!rst_n)
        step_shift |=> word_q[WORD_W-1] == $past(chain_out))
        else $error("returned bit not placed at word MSB");
endmodule

// File: rtl/scan_lane_group.sv
// Module: one group's scan ring with its lane image. The ring is LANES
// segments of SEG_BITS joined into a loop; bit 0 is the serial output and
// new bits enter at the top. Capture loads the ring from the lanes and update
// writes the ring into the lanes.
// Assumes at most one of shift_en, capture_en, update_en is high per cycle.
module scan_lane_group #(
    parameter int LANES    = 4,
    parameter int SEG_BITS = 268
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic serial_in,
    input  logic capture_en,
    input  logic update_en,
    output logic serial_out
);
    localparam int LEN = LANES * SEG_BITS;

    // Computes the lane image reset value: a 1 on every third bit from bit 0.
    function automatic logic [LEN-1:0] lane_reset_image();
        logic [LEN-1:0] v;
        for (int i = 0; i < LEN; i++) v[i] = ((i % 3) == 0);
        return v;
    endfunction

    localparam logic [LEN-1:0] RESET_IMG = lane_reset_image();

    logic [LEN-1:0]      chain_q;
    logic [LEN-1:0]      lane_flat;
    logic [SEG_BITS-1:0] lane_q [LANES];

    // Ring register: capture has precedence, otherwise rotate one bit in from the top.
    always_ff @(posedge clk) begin
        if (!rst_n)          chain_q <= '0;
        else if (capture_en) chain_q <= lane_flat;
        else if (shift_en)   chain_q <= {serial_in, chain_q[LEN-1:1]};
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Lane segment register: takes its slice of the ring on update.
        always_ff @(posedge clk) begin
            if (!rst_n)         lane_q[l] <= RESET_IMG[l*SEG_BITS +: SEG_BITS];
            else if (update_en) lane_q[l] <= chain_q[l*SEG_BITS +: SEG_BITS];
        end
        assign lane_flat[l*SEG_BITS +: SEG_BITS] = lane_q[l];
    end

    assign serial_out = chain_q[0];

    a_r9_enter_top: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && !capture_en |=> chain_q[LEN-1] == $past(serial_in))
        else $error("shifted bit did not enter ring top");
    a_r11_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> chain_q == $past(lane_flat)) else $error("capture mismatch");
    a_r12_update_applies: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> lane_flat == $past(chain_q)) else $error("update mismatch");
endmodule

// File: rtl/scan_ring_engine.sv
// Module: top of the serial scan ring engine. Connects the register
// sequencer and the divider to NUM_GROUPS lane groups, and chooses the
// observed serial return, taking the bypass setting into account.
// Assumes NUM_GROUPS is a power of two and at least 2.
module scan_ring_engine
    import scan_ring_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int LANES      = 4,
    parameter int SEG_BITS   = 268,
    parameter int DIV_W      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        scan_clk
);
    localparam int OBS_W = $clog2(NUM_GROUPS);

    logic                  tick;
    logic                  chain_out;
    logic                  busy;
    logic                  step_shift;
    logic                  step_cap;
    logic                  step_upd;
    logic                  word_lsb;
    logic [DIV_W-1:0]      run_div;
    logic [OBS_W-1:0]      obs_sel;
    logic [NUM_GROUPS-1:0] bypass;
    logic [NUM_GROUPS-1:0] group_sel;
    logic [NUM_GROUPS-1:0] grp_out;

    scan_ctrl_regs #(.NUM_GROUPS(NUM_GROUPS), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .chain_out(chain_out), .busy(busy), .step_shift(step_shift),
        .step_cap(step_cap), .step_upd(step_upd), .word_lsb(word_lsb),
        .run_div(run_div), .obs_sel(obs_sel), .bypass(bypass), .group_sel(group_sel)
    );

    scan_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .div_exp(run_div),
        .tick(tick), .scan_clk(scan_clk)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        scan_lane_group #(.LANES(LANES), .SEG_BITS(SEG_BITS)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .shift_en(step_shift && group_sel[g] && !bypass[g]),
            .serial_in(word_lsb),
            .capture_en(step_cap && group_sel[g]),
            .update_en(step_upd && group_sel[g]),
            .serial_out(grp_out[g])
        );
    end

    // Observed return: a bypassed group passes the serial input straight back.
    always_comb begin
        chain_out = bypass[obs_sel] ? word_lsb : grp_out[obs_sel];
    end

    a_r10_bypass_loop: assert property (@(posedge clk) disable iff (!rst_n)
        step_shift && bypass[obs_sel] |-> chain_out == word_lsb)
        else $error("bypassed group not transparent");
endmodule

// File: tb/scan_ring_engine_test.sv
module scan_ring_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        scan_clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_ring_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scan_clk(scan_clk)
    );

    // Table rows: {exponent[3:0], bits[5:0], word[31:0]}; run with the observed group bypassed.
    localparam logic [41:0] VEC [6] = '{
        {4'd0, 6'd1,  32'hA5A5F00F},
        {4'd0, 6'd32, 32'h12345678},
        {4'd1, 6'd5,  32'hDEADBEEF},
        {4'd2, 6'd17, 32'h80000001},
        {4'd0, 6'd31, 32'h0F0F1234},
        {4'd3, 6'd8,  32'hCAFEBABE}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_data(input logic [31:0] w, input int n,
                                            input logic [1:0] sel, input logic [2:0] cmd);
        logic [63:0] d = '0;
        d[31:0]  = w;
        d[36:32] = 5'(n - 1);
        d[41:40] = sel;
        d[58:56] = cmd;
        return d;
    endfunction

    function automatic logic [63:0] mk_ctl(input int e, input int obs, input logic [1:0] byp);
        logic [63:0] c = '0;
        c[3:0]   = 4'(e);
        c[8]     = obs[0];
        c[17:16] = byp;
        return c;
    endfunction

    // Lane reset pattern bits starting at ring position off.
    function automatic logic [31:0] pat_bits(input int off, input int n);
        logic [31:0] r = '0;
        for (int j = 0; j < n; j++) r[j] = (((off + j) % 3) == 0);
        return r;
    endfunction

    function automatic logic [31:0] after_shift(input logic [31:0] w, input int n, input logic [31:0] ret);
        if (n == 32) return ret;
        return (w >> n) | (ret << (32 - n));
    endfunction

    task automatic wr_reg(input logic a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        int guard = 0;
        reg_addr = 1'b1;
        #1;
        while (reg_rdata[58:56] != 3'b000 && guard < 200000) begin
            @(negedge clk); #1; guard++;
        end
    endtask

    task automatic do_op(input logic [63:0] d, output int cyc, output int rises, output logic [31:0] w);
        bit prev;
        @(negedge clk);
        reg_addr = 1'b1; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        cyc = 0; rises = 0; prev = 1'b0;
        #1;
        while (reg_rdata[58:56] != 3'b000 && cyc < 200000) begin
            cyc++;
            if (scan_clk && !prev) rises++;
            prev = scan_clk;
            @(negedge clk); #1;
        end
        w = reg_rdata[31:0];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R6 watchdog expired actual=busy expected=idle");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [31:0] w;
        logic [31:0] res;
        int cyc, rises, e, n;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_reg(1'b0, v); chk(v == 64'd0, "R1 control reset", v, 64'd0);
        rd_reg(1'b1, v); chk(v == 64'd0, "R1 data reset", v, 64'd0);
        chk(scan_clk == 1'b0, "R1 scan clock idle", 64'(scan_clk), 64'd0);

        // R2: control readback of defined fields, undefined bits dropped
        wr_reg(1'b0, mk_ctl(5, 1, 2'b10));
        rd_reg(1'b0, v); chk(v == mk_ctl(5, 1, 2'b10), "R2 control readback", v, mk_ctl(5, 1, 2'b10));
        wr_reg(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_reg(1'b0, v); chk(v == mk_ctl(15, 1, 2'b11), "R2 undefined bits zero", v, mk_ctl(15, 1, 2'b11));

        // Table walk, R10 rotation through bypass, R6 busy length, R4 edge count
        for (int i = 0; i < 6; i++) begin
            e = int'(VEC[i][41:38]);
            n = int'(VEC[i][37:32]);
            w = VEC[i][31:0];
            wr_reg(1'b0, mk_ctl(e, 0, 2'b11));
            do_op(mk_data(w, n, 2'b01, 3'b001), cyc, rises, res);
            chk(res == after_shift(w, n, w << (32 - n) >> (32 - n)), "R10 bypass rotate",
                64'(res), 64'(after_shift(w, n, w << (32 - n) >> (32 - n))));
            chk(cyc == (1 << (e + 1)) + (n - 1) * (1 << (e + 2)) + 1, "R6 shift busy cycles",
                64'(cyc), 64'((1 << (e + 1)) + (n - 1) * (1 << (e + 2)) + 1));
            chk(rises == n, "R4 scan edges per bit", 64'(rises), 64'(n));
            chk(scan_clk == 1'b0, "R4 scan clock low when idle", 64'(scan_clk), 64'd0);
        end

        // R13 and R11: capture group 0 only, then shift group 1 while observing group 0
        wr_reg(1'b0, mk_ctl(0, 0, 2'b00));
        do_op(mk_data(32'h0, 1, 2'b01, 3'b010), cyc, rises, res);
        chk(cyc == 3, "R6 capture busy cycles", 64'(cyc), 64'd3);
        do_op(mk_data(32'h0, 8, 2'b10, 3'b001), cyc, rises, res);
        chk(res == 32'hFF00_0000, "R13 unselected group holds", 64'(res), 64'hFF00_0000);
        wr_reg(1'b0, mk_ctl(0, 1, 2'b00));
        do_op(mk_data(32'h0, 8, 2'b10, 3'b001), cyc, rises, res);
        chk(res == 32'h0, "R13 capture limited to selected group", 64'(res), 64'h0);
        wr_reg(1'b0, mk_ctl(0, 0, 2'b00));
        do_op(mk_data(32'h0, 32, 2'b01, 3'b001), cyc, rises, res);
        chk(res == pat_bits(0, 32), "R11 captured lane pattern", 64'(res), 64'(pat_bits(0, 32)));
        do_op(mk_data(32'hFFFF_FFF0, 4, 2'b01, 3'b001), cyc, rises, res);
        chk(res == after_shift(32'hFFFF_FFF0, 4, pat_bits(32, 4)), "R5 upper bits hold return",
            64'(res), 64'(after_shift(32'hFFFF_FFF0, 4, pat_bits(32, 4))));

        // R12: update then disturb then capture must reproduce the updated image
        do_op(mk_data(32'h0, 1, 2'b01, 3'b010), cyc, rises, res);
        do_op(mk_data(32'hFFFF_FFFF, 32, 2'b01, 3'b001), cyc, rises, res);
        chk(res == pat_bits(0, 32), "R11 recapture pattern", 64'(res), 64'(pat_bits(0, 32)));
        do_op(mk_data(32'h0, 1, 2'b01, 3'b100), cyc, rises, res);
        chk(cyc == 3, "R6 update busy cycles", 64'(cyc), 64'd3);
        do_op(mk_data(32'h0, 32, 2'b01, 3'b001), cyc, rises, res);
        chk(res == pat_bits(32, 32), "R5 next ring bits", 64'(res), 64'(pat_bits(32, 32)));
        do_op(mk_data(32'h0, 1, 2'b01, 3'b010), cyc, rises, res);
        do_op(mk_data(32'h0, 32, 2'b01, 3'b001), cyc, rises, res);
        chk(res == pat_bits(32, 32), "R12 update applied to lanes", 64'(res), 64'(pat_bits(32, 32)));

        // R9: full trip around group 1's 1072-bit ring
        wr_reg(1'b0, mk_ctl(0, 1, 2'b00));
        do_op(mk_data(32'h1357_9BDF, 32, 2'b10, 3'b001), cyc, rises, res);
        chk(res == 32'h0, "R9 empty ring returns zero", 64'(res), 64'h0);
        for (int k = 0; k < 32; k++) do_op(mk_data(32'h0, 32, 2'b10, 3'b001), cyc, rises, res);
        do_op(mk_data(32'h0, 16, 2'b10, 3'b001), cyc, rises, res);
        do_op(mk_data(32'h0, 32, 2'b10, 3'b001), cyc, rises, res);
        chk(res == 32'h1357_9BDF, "R9 word returns after 1072 bits", 64'(res), 64'h1357_9BDF);

        // R7: a second write during a running shift is dropped
        wr_reg(1'b0, mk_ctl(3, 0, 2'b11));
        wr_reg(1'b1, mk_data(32'h0000_00F1, 4, 2'b01, 3'b001));
        wr_reg(1'b1, mk_data(32'hAAAA_AAAA, 9, 2'b10, 3'b011));
        wait_idle();
        rd_reg(1'b1, v);
        chk(v == mk_data(32'h1000_000F, 4, 2'b01, 3'b000), "R7 busy write ignored",
            v, mk_data(32'h1000_000F, 4, 2'b01, 3'b000));

        // R8 and R3: priority among simultaneous command bits
        wr_reg(1'b1, mk_data(32'h0, 2, 2'b00, 3'b111));
        rd_reg(1'b1, v);
        chk(v[58:56] == 3'b001, "R8 shift beats capture and update", 64'(v[58:56]), 64'd1);
        wait_idle();
        wr_reg(1'b1, mk_data(32'h0, 1, 2'b00, 3'b110));
        rd_reg(1'b1, v);
        chk(v[58:56] == 3'b010, "R8 capture beats update", 64'(v[58:56]), 64'd2);
        chk(v[41:40] == 2'b00 && v[36:32] == 5'd0, "R3 data fields readback", v, 64'd0);
        wait_idle();
        rd_reg(1'b1, v);
        chk(v[58:56] == 3'b000, "R6 command cleared", 64'(v[58:56]), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule